// File: doc/BRIEF.md
# Lite UART Register Front-End

This block is the bus-facing half of a small serial port. A 32-bit memory-mapped bus reaches four word registers: receive data, transmit data, status and control. A bit-level serializer that sits beside the block hands in received bytes as a byte-valid stream. These bytes collect in an eight-deep FIFO until software reads them. A write to the transmit register sends its low byte out on a byte-valid stream on the next cycle, so the transmit side never fills.

Status holds the FIFO level flags and an interrupt-pending flag. It also holds three sticky error flags. The overrun flag is raised inside the block. The framing and parity flags are raised by pulses from the serializer. The level interrupt output is the pending flag gated by the enable bit in control. A receive soft reset in control empties the FIFO and clears the error flags. A write to the status register changes nothing and is reported on an error strobe.

Top module: `lite_uart_regs`

## Requirements
- R1: The register index is the byte address shifted right by two. Index 0 is receive data, 1 is transmit data, 2 is status and 3 is control. Indexes 4 to 7 read as zero, and writes to them change no register.
- R2: Status reads as follows: bit0 receive data present, bit1 FIFO holds 8 bytes, bit2 always 1, bit3 always 0, bit4 interrupt pending, bit5 overrun, bit6 framing error, bit7 parity error. After reset, status reads 0x04, control reads 0, irq is 0, rxReady is 1 and txValid is 0.
- R3: The receive FIFO holds 8 bytes, returns them oldest first, and its pointer wraps modulo 8.
- R4: rxReady is 1 exactly when the FIFO holds fewer than 8 bytes. A byte offered while it holds 8 is dropped, and overrun (bit5) is set.
- R5: Reading index 0 returns the oldest byte in bits 7:0 and removes it. Reading index 0 when the FIFO is empty returns the byte in the slot at the write pointer and leaves the count at zero.
- R6: A control write stores the whole word, which reads back at index 3. If bit1 of the written value is set, the FIFO becomes empty and status bits 5 to 7 clear.
- R7: A write to index 1 drives txByte with bits 7:0 and raises txValid for exactly the next cycle. The written word reads back at index 1.
- R8: Interrupt pending is set by a transmit write and by a non-empty FIFO. It clears after a status read made while the FIFO is empty.
- R9: irq equals interrupt pending AND control bit4.
- R10: A write to index 2 leaves status unchanged and raises statusWrErr for the one following cycle.
- R11: A one-cycle pulse on frameErrIn sets status bit6, and a pulse on parityErrIn sets bit7. Both bits stay set until a receive soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busAddr | input | ADDR_W | Byte address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of busRd |
| rxValid | input | 1 | Received byte offered |
| rxByte | input | 8 | Received byte |
| rxReady | output | 1 | FIFO has space |
| frameErrIn | input | 1 | Framing error pulse |
| parityErrIn | input | 1 | Parity error pulse |
| txValid | output | 1 | Transmit byte valid |
| txByte | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |
| statusWrErr | output | 1 | Illegal status write strobe |

## Verification
On every cycle, the assertions check that the FIFO count never exceeds its depth and that no push is issued into a full FIFO. They also check that a pop without a push lowers the count by one, that a soft reset empties the FIFO, that a non-empty FIFO always holds the pending flag, and that a transmit load and a status write each give their one-cycle pulse. The oldest-first byte order, the stale byte returned by an empty read, the packed status values and readback of the stored registers can only be shown by the bench scenarios. The same holds for the ordering that clears the pending flag and for the interrupt gating by the enable bit.

// File: rtl/lite_uart_pkg.sv
package lite_uart_pkg;
  localparam int unsigned REG_RX     = 0;
  localparam int unsigned REG_TX     = 1;
  localparam int unsigned REG_STATUS = 2;
  localparam int unsigned REG_CTRL   = 3;
  localparam int unsigned CTRL_RXRST_BIT = 1;
  localparam int unsigned CTRL_IE_BIT    = 4;

  typedef struct packed {
    logic popRx;
    logic pushRx;
    logic rxClear;
    logic txLoad;
    logic ctrlLoad;
    logic setOverrun;
  } uartStrobes_t;
endpackage

// File: rtl/lite_uart_ctrl.sv
module lite_uart_ctrl
  import lite_uart_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [IDX_W-1:0] regIdx,
  input  logic             rxClearBit,
  input  logic             rxValid,
  input  logic [CNT_W-1:0] rxCount,
  output uartStrobes_t     strobes,
  output logic             ipend,
  output logic             statusWrErr
);
  logic             isFull;
  logic             statusRd;
  logic [CNT_W-1:0] countNext;
  logic             ipendNext;

  assign isFull   = (rxCount == CNT_W'(DEPTH));
  assign statusRd = busRd && (regIdx == IDX_W'(REG_STATUS));

  always_comb begin
    strobes.ctrlLoad   = busWr && (regIdx == IDX_W'(REG_CTRL));
    strobes.rxClear    = strobes.ctrlLoad && rxClearBit;
    strobes.txLoad     = busWr && (regIdx == IDX_W'(REG_TX));
    strobes.popRx      = busRd && (regIdx == IDX_W'(REG_RX)) && (rxCount != '0);
    strobes.pushRx     = rxValid && !isFull && !strobes.rxClear;
    strobes.setOverrun = rxValid && isFull && !strobes.rxClear;
  end

  always_comb begin
    if (strobes.rxClear) countNext = '0;
    else countNext = rxCount + CNT_W'(strobes.pushRx) - CNT_W'(strobes.popRx);
    ipendNext = strobes.txLoad || (countNext != '0) ||
                (ipend && !(statusRd && (rxCount == '0)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ipend       <= 1'b0;
      statusWrErr <= 1'b0;
    end else begin
      ipend       <= ipendNext;
      statusWrErr <= busWr && (regIdx == IDX_W'(REG_STATUS));
    end
  end

  a_r8_ipend_held: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount != '0) |-> ipend);
  a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && regIdx == IDX_W'(REG_STATUS)) |=> statusWrErr);
  a_r8_tx_sets: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txLoad |=> ipend);
endmodule

// File: rtl/lite_uart_datapath.sv
module lite_uart_datapath
  import lite_uart_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  uartStrobes_t     strobes,
  input  logic [31:0]      wdata,
  input  logic [7:0]       rxByte,
  input  logic             frameErrIn,
  input  logic             parityErrIn,
  input  logic [IDX_W-1:0] regIdx,
  input  logic             ipend,
  output logic [CNT_W-1:0] rxCount,
  output logic             rxReady,
  output logic             ctrlIe,
  output logic             txValid,
  output logic [7:0]       txByte,
  output logic [31:0]      rdata
);
  logic [7:0]       fifoMem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [31:0]      ctrlReg;
  logic [31:0]      txReg;
  logic             errOverrun;
  logic             errFrame;
  logic             errParity;
  logic [7:0]       statusByte;

  assign rdPtr   = wrPtr - rxCount[PTR_W-1:0];
  assign rxReady = (rxCount < CNT_W'(DEPTH));
  assign ctrlIe  = ctrlReg[CTRL_IE_BIT];

  always_ff @(posedge clk) begin
    if (strobes.pushRx) fifoMem[wrPtr] <= rxByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rxCount <= '0;
    end else if (strobes.rxClear) begin
      wrPtr   <= '0;
      rxCount <= '0;
    end else begin
      if (strobes.pushRx) wrPtr <= wrPtr + 1'b1;
      rxCount <= rxCount + CNT_W'(strobes.pushRx) - CNT_W'(strobes.popRx);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errOverrun <= 1'b0;
      errFrame   <= 1'b0;
      errParity  <= 1'b0;
    end else if (strobes.rxClear) begin
      errOverrun <= 1'b0;
      errFrame   <= 1'b0;
      errParity  <= 1'b0;
    end else begin
      if (strobes.setOverrun) errOverrun <= 1'b1;
      if (frameErrIn)         errFrame   <= 1'b1;
      if (parityErrIn)        errParity  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      txReg   <= '0;
      txValid <= 1'b0;
      txByte  <= '0;
    end else begin
      if (strobes.ctrlLoad) ctrlReg <= wdata;
      if (strobes.txLoad) begin
        txReg  <= wdata;
        txByte <= wdata[7:0];
      end
      txValid <= strobes.txLoad;
    end
  end

  assign statusByte = {errParity, errFrame, errOverrun, ipend, 1'b0, 1'b1,
                       (rxCount == CNT_W'(DEPTH)), (rxCount != '0)};

  always_comb begin
    unique case (regIdx)
      IDX_W'(REG_RX):     rdata = {24'd0, fifoMem[rdPtr]};
      IDX_W'(REG_TX):     rdata = txReg;
      IDX_W'(REG_STATUS): rdata = {24'd0, statusByte};
      IDX_W'(REG_CTRL):   rdata = ctrlReg;
      default:            rdata = '0;
    endcase
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(DEPTH));
  a_r4_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.pushRx && rxCount == CNT_W'(DEPTH)));
  a_r5_pop_dec: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.popRx && !strobes.pushRx && !strobes.rxClear) |=>
      rxCount == $past(rxCount) - 1'b1);
  a_r6_clear_empty: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rxClear |=> (rxCount == '0) && !errOverrun);
  a_r7_tx_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txLoad |=> txValid);
endmodule

// File: rtl/lite_uart_regs.sv
module lite_uart_regs
  import lite_uart_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned IDX_W = ADDR_W - 2,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              rxReady,
  input  logic              frameErrIn,
  input  logic              parityErrIn,
  output logic              txValid,
  output logic [7:0]        txByte,
  output logic              irq,
  output logic              statusWrErr
);
  uartStrobes_t     strobes;
  logic [IDX_W-1:0] regIdx;
  logic [1:0]       unusedByteLane;
  logic [CNT_W-1:0] rxCount;
  logic             ipend;
  logic             ctrlIe;

  assign regIdx         = busAddr[ADDR_W-1:2];
  assign unusedByteLane = busAddr[1:0];

  lite_uart_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .regIdx(regIdx),
    .rxClearBit(busWdata[CTRL_RXRST_BIT]), .rxValid(rxValid),
    .rxCount(rxCount), .strobes(strobes), .ipend(ipend),
    .statusWrErr(statusWrErr)
  );

  lite_uart_datapath #(.DEPTH(DEPTH), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wdata(busWdata),
    .rxByte(rxByte), .frameErrIn(frameErrIn), .parityErrIn(parityErrIn),
    .regIdx(regIdx), .ipend(ipend), .rxCount(rxCount), .rxReady(rxReady),
    .ctrlIe(ctrlIe), .txValid(txValid), .txByte(txByte), .rdata(busRdata)
  );

  assign irq = ipend && ctrlIe;
endmodule

// File: tb/lite_uart_regs_tb.sv
module lite_uart_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxReady;
  logic        frameErrIn = 1'b0;
  logic        parityErrIn = 1'b0;
  logic        txValid;
  logic [7:0]  txByte;
  logic        irq;
  logic        statusWrErr;

  int checkCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lite_uart_regs dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rxValid(rxValid),
    .rxByte(rxByte), .rxReady(rxReady), .frameErrIn(frameErrIn),
    .parityErrIn(parityErrIn), .txValid(txValid), .txByte(txByte),
    .irq(irq), .statusWrErr(statusWrErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busRead(input logic [4:0] addr, output logic [31:0] data);
    @(negedge clk);
    busRd = 1'b1; busAddr = addr;
    #1 data = busRdata;
    @(posedge clk);
    #1 busRd = 1'b0;
  endtask

  task automatic busWrite(input logic [4:0] addr, input logic [31:0] data);
    @(negedge clk);
    busWr = 1'b1; busAddr = addr; busWdata = data;
    @(posedge clk);
    #1 busWr = 1'b0;
  endtask

  task automatic rxPush(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(posedge clk);
    #1 rxValid = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    @(negedge clk);
    chk("R2 reset irq", irq, 0);
    chk("R2 reset rxReady", rxReady, 1);
    chk("R2 reset txValid", txValid, 0);
    busRead(5'h08, d); chk("R2 reset status", d, 32'h04);
    busRead(5'h0C, d); chk("R2 reset ctrl", d, 0);
  endtask

  task automatic testOrder();
    logic [31:0] d;
    rxPush(8'h11); rxPush(8'h22); rxPush(8'h33);
    busRead(5'h08, d); chk("R2 status three bytes", d, 32'h15);
    busRead(5'h00, d); chk("R3 first byte", d, 32'h11);
    busRead(5'h00, d); chk("R3 second byte", d, 32'h22);
    busRead(5'h00, d); chk("R5 third byte", d, 32'h33);
    busRead(5'h08, d); chk("R8 pending held after drain", d, 32'h14);
    busRead(5'h08, d); chk("R8 pending cleared by status read", d, 32'h04);
  endtask

  task automatic testFull();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      chk("R4 ready before full", rxReady, 1);
      rxPush(8'h40 + 8'(i));
    end
    @(negedge clk);
    chk("R4 ready low when full", rxReady, 0);
    rxPush(8'h48); rxPush(8'h49);
    busRead(5'h08, d); chk("R4 full with overrun", d, 32'h37);
    for (int i = 0; i < 8; i++) begin
      busRead(5'h00, d); chk("R3 wrapped order", d, 32'h40 + i);
    end
    busRead(5'h00, d); chk("R5 empty read stale slot", d, 32'h40);
    busRead(5'h08, d); chk("R5 empty stays empty", d, 32'h34);
    busWrite(5'h0C, 32'h0000_0102);
    busRead(5'h08, d); chk("R6 soft reset clears overrun", d, 32'h04);
    busRead(5'h0C, d); chk("R6 control stored", d, 32'h0000_0102);
  endtask

  task automatic testClearNonEmpty();
    logic [31:0] d;
    rxPush(8'h5A); rxPush(8'h6B);
    busWrite(5'h0C, 32'h02);
    busRead(5'h08, d); chk("R6 clear empties FIFO", d, 32'h14);
    rxPush(8'h77);
    busRead(5'h00, d); chk("R6 pointer restarts", d, 32'h77);
    busRead(5'h08, d);
    busWrite(5'h0C, 32'h00);
  endtask

  task automatic testTx();
    logic [31:0] d;
    busWrite(5'h04, 32'h0000_01A5);
    chk("R7 txValid", txValid, 1);
    chk("R7 txByte", txByte, 32'hA5);
    chk("R9 irq masked", irq, 0);
    @(negedge clk); @(posedge clk); #1;
    chk("R7 txValid one cycle", txValid, 0);
    busRead(5'h04, d); chk("R7 tx readback", d, 32'h1A5);
    busWrite(5'h0C, 32'h10);
    chk("R9 irq enabled", irq, 1);
    busRead(5'h08, d); chk("R8 pending from tx", d, 32'h14);
    chk("R9 irq cleared", irq, 0);
    rxPush(8'h99);
    chk("R9 irq on rx", irq, 1);
    busRead(5'h00, d); chk("R3 rx byte", d, 32'h99);
    chk("R8 irq held after drain", irq, 1);
    busRead(5'h08, d);
    chk("R8 irq cleared after status", irq, 0);
    busWrite(5'h0C, 32'h00);
  endtask

  task automatic testMisc();
    logic [31:0] d;
    busWrite(5'h08, 32'hFF);
    chk("R10 error strobe", statusWrErr, 1);
    @(negedge clk); @(posedge clk); #1;
    chk("R10 strobe one cycle", statusWrErr, 0);
    busRead(5'h08, d); chk("R10 status unchanged", d, 32'h04);
    busRead(5'h10, d); chk("R1 unused reads zero", d, 0);
    busWrite(5'h14, 32'hFFFF_FFFF);
    busRead(5'h0C, d); chk("R1 unused write no effect ctrl", d, 0);
    busRead(5'h08, d); chk("R1 unused write no effect status", d, 32'h04);
    @(negedge clk); frameErrIn = 1'b1;
    @(posedge clk); #1 frameErrIn = 1'b0;
    busRead(5'h08, d); chk("R11 framing bit", d, 32'h44);
    @(negedge clk); parityErrIn = 1'b1;
    @(posedge clk); #1 parityErrIn = 1'b0;
    busRead(5'h08, d); chk("R11 sticky both", d, 32'hC4);
    busWrite(5'h0C, 32'h02);
    busRead(5'h08, d); chk("R11 cleared by soft reset", d, 32'h04);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testOrder();
    testFull();
    testClearNonEmpty();
    testTx();
    testMisc();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end
endmodule